// File: doc/BRIEF.md
# Bit-Sliced Configurable Logic Tile

This block is one logic tile of a fabric built for datapaths. It holds four clusters, one per bit-slice. Each cluster holds a set of logic elements. An element is a 4-input lookup table followed by a D flip-flop. A configuration bit picks whether the element presents the table value directly or the registered value. Each cluster has a full crossbar of local routing. Any lookup-table input can take any of the cluster's own input pins, the flip-flop output of any element in that cluster, or either incoming carry.

Two carry chains cross the tile from cluster 0 to cluster 3. In each cluster and for each chain, a configuration field names the element whose table output becomes that chain's carry into the next cluster. A 4-bit adder therefore fits in one tile, with one bit-slice per cluster. Configuration is shifted in serially while a load enable is high, and it is then held. During loading, the logic outputs are forced low and every flip-flop is held at 0.

Top module: `dp_supercluster`

## Requirements
- R1: A synchronous reset clears every configuration bit and every flip-flop. From the cycle after reset, all element outputs, both carry outputs and the serial output read 0, whatever the inputs are.
- R2: While the load enable is high, each clock shifts the configuration store up by one place. The new bit enters at bit 0 and the top bit (index 543) drives the serial output, so the first bit sent ends at the top. While the enable is low, the store and the serial output do not change.
- R3: While the load enable is high, every element output and both carry outputs read 0, and every flip-flop is cleared on each clock.
- R4: Element j of cluster k owns a 33-bit configuration field starting at bit k*136 + j*33. Bits 15:0 of the field hold the truth table, and the table output is bit {in3,in2,in1,in0}. Bits 16+4i to 19+4i hold the source code for table input i. Bit 32 selects the registered output.
- R5: Source codes inside a cluster are: 0 to 7 for cluster input pins 0 to 7 (tile pin k*8+n), 8 to 11 for the flip-flop of element 0 to 3, 12 and 13 for incoming carry 0 and 1, and 14 and 15 for constant 0.
- R6: With bit 32 at 0, the element output follows its table combinationally. With bit 32 at 1, it shows the flip-flop, which captures the table output at each clock edge.
- R7: For chain c of cluster k, the 2-bit field at bit k*136 + 132 + 2c names the element whose table output is the chain's carry-out. That carry-out is the incoming carry of cluster k+1. Tile carry input c enters cluster 0, and tile carry output c comes from cluster 3.
- R8: A flip-flop fed back to its own table toggles on every clock after loading ends, starting from 0.
- R9: The two carry chains are independent. A chain whose selected elements hold all-zero tables outputs 0 whatever the other chain carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Configuration load enable |
| cfg_din | input | 1 | Serial configuration data |
| cfg_dout | output | 1 | Top bit of the configuration store, used to chain tiles |
| clu_in | input | 32 | Cluster input pins, 8 per cluster, cluster k at bits k*8+7:k*8 |
| cy_in | input | 2 | Carry into cluster 0, one per chain |
| ble_out | output | 16 | Element outputs, element j of cluster k at bit k*4+j |
| cy_out | output | 2 | Carry out of cluster 3, one per chain |

## Verification
A single wrong configuration bit changes a table entry, a source or a carry selection. It shows on the sum or carry of an adder set up through that field, in the same cycle as the operands for combinational elements, or one edge later for registered ones. A wrong flip-flop state shows on the registered output after the next edge and propagates through feedback. A toggling element therefore exposes a missed clear or a stuck flip-flop within two cycles. A slip in the shift chain moves the whole layout and corrupts the adder outright. It also changes the serial output that is seen right after loading.

// File: rtl/dp_supercluster.sv
module dp_supercluster #(
  parameter int NCL    = 4,
  parameter int NBLE   = 4,
  parameter int K      = 4,
  parameter int NIN    = 8,
  parameter int NCHAIN = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_en,
  input  logic                   cfg_din,
  output logic                   cfg_dout,
  input  logic [NCL*NIN-1:0]     clu_in,
  input  logic [NCHAIN-1:0]      cy_in,
  output logic [NCL*NBLE-1:0]    ble_out,
  output logic [NCHAIN-1:0]      cy_out
);
  localparam int NSRC  = NIN + NBLE + NCHAIN;
  localparam int SW    = $clog2(NSRC + 1);
  localparam int TW    = 1 << K;
  localparam int BSW   = (NBLE > 1) ? $clog2(NBLE) : 1;
  localparam int BLE_W = TW + K*SW + 1;
  localparam int CL_W  = NBLE*BLE_W + NCHAIN*BSW;
  localparam int CFG_W = NCL*CL_W;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk)
    if (rst)         cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};

  assign cfg_dout = cfg_q[CFG_W-1];

  for (genvar k = 0; k < NCL; k++) begin : g_cl
    localparam int BASE = k*CL_W;
    logic [NCHAIN-1:0] ci, co;
    logic [NBLE-1:0]   q, lut;
    logic [NSRC-1:0]   src;

    if (k == 0) begin : g_head
      assign ci = cy_in;
    end else begin : g_link
      assign ci = g_cl[k-1].co;
    end

    assign src = {ci, q, clu_in[k*NIN +: NIN]};

    for (genvar j = 0; j < NBLE; j++) begin : g_ble
      localparam int B = BASE + j*BLE_W;
      logic [TW-1:0] tt;
      logic [K-1:0]  li;
      logic          reg_mode, qb;

      assign tt       = cfg_q[B +: TW];
      assign reg_mode = cfg_q[B + TW + K*SW];

      for (genvar i = 0; i < K; i++) begin : g_pin
        logic [SW-1:0] s;
        assign s     = cfg_q[B + TW + i*SW +: SW];
        assign li[i] = (int'(s) < NSRC) ? src[s] : 1'b0;
      end

      assign lut[j] = tt[li];

      always_ff @(posedge clk)
        if (rst || cfg_en) qb <= 1'b0;
        else               qb <= lut[j];

      assign q[j] = qb;
      assign ble_out[k*NBLE + j] = cfg_en ? 1'b0 : (reg_mode ? qb : lut[j]);
    end

    for (genvar c = 0; c < NCHAIN; c++) begin : g_cy
      logic [BSW-1:0] cs;
      assign cs    = cfg_q[BASE + NBLE*BLE_W + c*BSW +: BSW];
      assign co[c] = cfg_en ? 1'b0 : lut[cs];
    end
  end

  assign cy_out = g_cl[NCL-1].co;
endmodule

// File: rtl/dp_supercluster_chk.sv
module dp_supercluster_chk #(
  parameter int NCL    = 4,
  parameter int NBLE   = 4,
  parameter int NCHAIN = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_en,
  input logic                cfg_dout,
  input logic                cfg_next,
  input logic [NCL*NBLE-1:0] ble_out,
  input logic [NCHAIN-1:0]   cy_out
);
  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (ble_out == '0 && cy_out == '0 && cfg_dout == 1'b0));

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_dout == $past(cfg_next));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_dout));

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (ble_out == '0 && cy_out == '0));
endmodule

bind dp_supercluster dp_supercluster_chk #(.NCL(NCL), .NBLE(NBLE), .NCHAIN(NCHAIN)) chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dout(cfg_dout),
  .cfg_next(cfg_q[CFG_W-2]), .ble_out(ble_out), .cy_out(cy_out));

// File: tb/dp_supercluster_tb_top.sv
module dp_supercluster_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLE_W = 33;
  localparam int CL_W  = 136;
  localparam int CFG_W = 544;

  // a[4] b[4] ci[1] expected {cout,sum}[5]
  localparam logic [13:0] VEC [12] = '{
    {4'h0, 4'h0, 1'b0, 5'h00}, {4'hF, 4'h1, 1'b0, 5'h10},
    {4'hF, 4'hF, 1'b1, 5'h1F}, {4'hA, 4'h5, 1'b0, 5'h0F},
    {4'hA, 4'h5, 1'b1, 5'h10}, {4'h7, 4'h8, 1'b1, 5'h10},
    {4'h3, 4'h4, 1'b0, 5'h07}, {4'h9, 4'h9, 1'b0, 5'h12},
    {4'hC, 4'h3, 1'b1, 5'h10}, {4'h6, 4'h6, 1'b1, 5'h0D},
    {4'hF, 4'h0, 1'b1, 5'h10}, {4'h1, 4'h2, 1'b0, 5'h03}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic        cfg_din = 1'b0;
  logic        cfg_dout;
  logic [31:0] clu_in = '0;
  logic [1:0]  cy_in = '0;
  logic [15:0] ble_out;
  logic [1:0]  cy_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [CFG_W-1:0] cfg_a, cfg_b;
  logic [15:0] t_xor, t_maj;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_supercluster dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .clu_in(clu_in), .cy_in(cy_in), .ble_out(ble_out), .cy_out(cy_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [BLE_W-1:0] ble_word(logic [15:0] tt, int s0, int s1, int s2, int s3, logic rm);
    return {rm, 4'(s3), 4'(s2), 4'(s1), 4'(s0), tt};
  endfunction

  function automatic logic [3:0] sums();
    return {ble_out[12], ble_out[8], ble_out[4], ble_out[0]};
  endfunction

  task automatic set_ops(logic [3:0] a, logic [3:0] b);
    clu_in = '0;
    for (int k = 0; k < 4; k++) begin
      clu_in[k*8]     = a[k];
      clu_in[k*8 + 1] = b[k];
    end
  endtask

  task automatic load(logic [CFG_W-1:0] v, logic gate_check);
    for (int n = 0; n < CFG_W; n++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[CFG_W-1-n];
      if (gate_check && n == 200) begin
        #1;
        chk("R3 outputs low while loading", {14'b0, cy_out, ble_out}, 32'h0);
      end
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      t_xor[i] = i[0] ^ i[1] ^ i[2];
      t_maj[i] = (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]);
    end
    cfg_a = '0;
    cfg_b = '0;
    for (int k = 0; k < 4; k++) begin
      cfg_a[k*CL_W +: BLE_W]         = ble_word(t_xor, 0, 1, 12, 15, 1'b0);
      cfg_a[k*CL_W + BLE_W +: BLE_W] = ble_word(t_maj, 0, 1, 12, 15, 1'b0);
      cfg_a[k*CL_W + 132 +: 2] = 2'd1;
      cfg_a[k*CL_W + 134 +: 2] = 2'd0;
      cfg_b[k*CL_W +: BLE_W]           = ble_word(t_xor, 0, 1, 13, 15, 1'b1);
      cfg_b[k*CL_W + 3*BLE_W +: BLE_W] = ble_word(t_maj, 0, 1, 13, 15, 1'b0);
      cfg_b[k*CL_W + 132 +: 2] = 2'd2;
      cfg_b[k*CL_W + 134 +: 2] = 2'd3;
    end
    cfg_b[2*BLE_W +: BLE_W] = ble_word(16'h5555, 10, 15, 15, 15, 1'b1);

    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 outputs after reset", {13'b0, cfg_dout, cy_out, ble_out}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    clu_in = '1;
    cy_in = 2'b11;
    @(posedge clk); #1;
    chk("R1 cleared config ignores inputs", {13'b0, cfg_dout, cy_out, ble_out}, 32'h0);

    // R4 R5 R7: combinational adder on chain 0
    load(cfg_a, 1'b0);
    #1;
    chk("R2 serial out after load A", {31'b0, cfg_dout}, {31'b0, cfg_a[CFG_W-1]});
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      set_ops(VEC[v][13:10], VEC[v][9:6]);
      cy_in = {1'b0, VEC[v][5]};
      #1;
      chk("R7 R4 R5 R6 adder sum/carry", {27'b0, cy_out[0], sums()}, {27'b0, VEC[v][4:0]});
    end
    chk("R2 serial out held", {31'b0, cfg_dout}, {31'b0, cfg_a[CFG_W-1]});

    // R3: gating during load of config B, operands would give nonzero
    @(negedge clk);
    set_ops(4'hF, 4'hF);
    cy_in = 2'b11;
    load(cfg_b, 1'b1);
    #1;
    chk("R2 serial out after load B", {31'b0, cfg_dout}, 32'h1);

    // R8: toggle flip-flop, R6 registered sums on chain 1
    @(posedge clk); #1;
    chk("R8 toggle first edge", {31'b0, ble_out[2]}, 32'h1);
    chk("R6 registered sum F+F+1", {28'b0, sums()}, 32'hF);
    chk("R7 chain1 carry F+F+1", {31'b0, cy_out[1]}, 32'h1);
    @(posedge clk); #1;
    chk("R8 toggle second edge", {31'b0, ble_out[2]}, 32'h0);
    @(posedge clk); #1;
    chk("R8 toggle third edge", {31'b0, ble_out[2]}, 32'h1);

    @(negedge clk);
    set_ops(4'h5, 4'h6);
    cy_in = 2'b10;
    #1;
    chk("R6 registered sum not yet updated", {28'b0, sums()}, 32'hF);
    chk("R7 chain1 carry 5+6+1", {31'b0, cy_out[1]}, 32'h0);
    @(posedge clk); #1;
    chk("R6 registered sum 5+6+1", {28'b0, sums()}, 32'hC);

    @(negedge clk);
    set_ops(4'h9, 4'h8);
    cy_in = 2'b01;
    #1;
    chk("R9 chain0 idle with carry in", {31'b0, cy_out[0]}, 32'h0);
    chk("R7 chain1 carry 9+8+0", {31'b0, cy_out[1]}, 32'h1);
    @(posedge clk); #1;
    chk("R6 registered sum 9+8+0", {28'b0, sums()}, 32'h1);

    // R1: reset during operation
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset clears all", {13'b0, cfg_dout, cy_out, ble_out}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 stays clear after reset", {13'b0, cfg_dout, cy_out, ble_out}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule